// File: doc/BRIEF.md
# Configurable Multi-Source I/O Port

This block is a bus-mapped general-purpose I/O port. Each pin is configured on its own. A per-pin output selector decides what drives the pin: the CPU-written output register, a bit of an address captured from a multiplexed bus, an output of an external programmable-logic macrocell, or an external chip-select signal. A second per-pin choice decides whether the pin's driver is enabled by the CPU-written direction bit or by an external enable term. One bit of a port can therefore be a plain GPIO while its neighbour carries an address bit or a chip select.

The CPU reaches the block through a simple register bus. It writes the output, direction and control registers. It reads one source at a time through a shared read mux: the synchronised pin state, any of the three registers, or the live macrocell outputs. The source selection and enable choice come in as static configuration inputs. When the `CTRL_RT` parameter is set, a runtime control register can also force individual pins onto the latched address. A port can be narrowed down to a single pin through `PW`.

Top module: `mio_port`

## Requirements
- R1: After reset the output, direction and control registers read zero, so with `cfg_oe_src` = 0 every `pin_oe` bit is 0 and every pin whose `cfg_osel` is 00 drives the output-register value 0.
- R2: A write (`wr_en`=1 at a rising clock edge) to offset 1 loads the output register, to offset 2 the direction register, and to offset 3 the control register, each from `wr_data[PW-1:0]`. Any register not addressed keeps its value.
- R3: With its control bit at 0, pin i drives the source chosen by `cfg_osel[2i+1:2i]`: 00 is output-register bit i, 01 is latched address bit i, 10 is `mc_out[i]`, and 11 is `ecs_in[i]`.
- R4: With `CTRL_RT`=1, a control-register bit of 1 makes that pin drive its latched address bit, whatever `cfg_osel` holds.
- R5: The address latch follows `ad_in` while `ale` is 1 and holds its value while `ale` is 0.
- R6: `pin_oe[i]` equals direction-register bit i when `cfg_oe_src[i]` is 0, and equals `pt_oe[i]` when it is 1.
- R7: A read at offset 0 returns `pin_in` through a two-flop synchroniser. A change made between edges appears after the second following rising edge, and not after the first.
- R8: A read at offset 1, 2 or 3 returns the output, direction or control register, and a read at offset 4 returns the live `mc_out`. Bits above `PW` read zero.
- R9: A read at offsets 5 to 7 returns zero. A write to offset 0 or to offsets 4 to 7 changes no register and no pin output.
- R10: Pins are independent. One port can mix all four output sources and both enable sources at once, and each pin follows only its own configuration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the offset on `reg_addr` |
| ale | input | 1 | Address latch enable |
| ad_in | input | PW | Multiplexed address input |
| mc_out | input | PW | Macrocell outputs |
| pt_oe | input | PW | External output-enable terms |
| ecs_in | input | PW | External chip-select per pin |
| cfg_osel | input | 2*PW | Static output-source select, 2 bits per pin |
| cfg_oe_src | input | PW | Static enable-source select per pin |
| pin_in | input | PW | Pin input level |
| pin_out | output | PW | Pin output value |
| pin_oe | output | PW | Pin output enable |

## Verification
The assertions check on every cycle that register writes load and that registers not written hold their value. They also check that the address latch holds while its strobe is low, that a set control bit routes the address to the pin, and that unmapped offsets read zero. Only the bench scenarios can show the other behaviours. These are the full source-selection mapping across mixed configurations, the switch of enable source, the exact two-edge delay of the pin readback, and the reset state seen at the ports. The bench also checks that writes to offsets outside the map leave every register and pin unchanged.

// File: rtl/mio_pkg.sv
package mio_pkg;
    localparam int BUS_W = 8;
    localparam int AW    = 3;

    typedef enum logic [1:0] {
        SRC_DOUT = 2'b00,
        SRC_ADDR = 2'b01,
        SRC_MC   = 2'b10,
        SRC_ECS  = 2'b11
    } src_e;

    localparam logic [AW-1:0] OFF_PIN  = 3'd0;
    localparam logic [AW-1:0] OFF_DOUT = 3'd1;
    localparam logic [AW-1:0] OFF_DIR  = 3'd2;
    localparam logic [AW-1:0] OFF_CTRL = 3'd3;
    localparam logic [AW-1:0] OFF_MC   = 3'd4;
endpackage

// File: rtl/mio_regs.sv
module mio_regs
    import mio_pkg::*;
#(
    parameter int PW      = 8,
    parameter bit CTRL_RT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    reg_addr,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [PW-1:0]    pin_in,
    input  logic [PW-1:0]    mc_out,
    output logic [PW-1:0]    dout,
    output logic [PW-1:0]    dir,
    output logic [PW-1:0]    ctrl,
    output logic [BUS_W-1:0] rd_data
);
    typedef struct packed {
        logic [PW-1:0] dout;
        logic [PW-1:0] dir;
        logic [PW-1:0] ctrl;
        logic [PW-1:0] sync1;
        logic [PW-1:0] sync2;
    } regs_t;

    regs_t st_d, st_q;
    logic [PW-1:0] rd_sel;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = pin_in;
        st_d.sync2 = st_q.sync1;
        if (wr_en) begin
            if (reg_addr == OFF_DOUT) st_d.dout = wr_data[PW-1:0];
            if (reg_addr == OFF_DIR)  st_d.dir  = wr_data[PW-1:0];
            if (CTRL_RT && reg_addr == OFF_CTRL) st_d.ctrl = wr_data[PW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (reg_addr)
            OFF_PIN:  rd_sel = st_q.sync2;
            OFF_DOUT: rd_sel = st_q.dout;
            OFF_DIR:  rd_sel = st_q.dir;
            OFF_CTRL: rd_sel = st_q.ctrl;
            OFF_MC:   rd_sel = mc_out;
            default:  rd_sel = '0;
        endcase
        rd_data = (reg_addr > OFF_MC) ? '0 : BUS_W'(rd_sel);
    end

    assign dout = st_q.dout;
    assign dir  = st_q.dir;
    assign ctrl = st_q.ctrl;

    // R2
    dout_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == OFF_DOUT) |=> dout == $past(wr_data[PW-1:0]));
    // R2
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_addr == OFF_DIR) |=> $stable(dir));
    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > OFF_MC) |-> rd_data == '0);
endmodule

// File: rtl/mio_pin_mux.sv
module mio_pin_mux
    import mio_pkg::*;
#(
    parameter int PW      = 8,
    parameter bit CTRL_RT = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PW-1:0]   dout,
    input  logic [PW-1:0]   dir,
    input  logic [PW-1:0]   ctrl,
    input  logic [PW-1:0]   addr_lat,
    input  logic [PW-1:0]   mc_out,
    input  logic [PW-1:0]   pt_oe,
    input  logic [PW-1:0]   ecs_in,
    input  logic [2*PW-1:0] cfg_osel,
    input  logic [PW-1:0]   cfg_oe_src,
    output logic [PW-1:0]   pin_out,
    output logic [PW-1:0]   pin_oe
);
    for (genvar i = 0; i < PW; i++) begin : g_pin
        src_e sel;
        always_comb begin
            if (CTRL_RT && ctrl[i]) sel = SRC_ADDR;
            else                    sel = src_e'(cfg_osel[2*i +: 2]);
            case (sel)
                SRC_DOUT: pin_out[i] = dout[i];
                SRC_ADDR: pin_out[i] = addr_lat[i];
                SRC_MC:   pin_out[i] = mc_out[i];
                default:  pin_out[i] = ecs_in[i];
            endcase
            pin_oe[i] = cfg_oe_src[i] ? pt_oe[i] : dir[i];
        end

        // R4
        ctrl_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (CTRL_RT && ctrl[i]) |-> pin_out[i] == addr_lat[i]);
    end
endmodule

// File: rtl/mio_port.sv
module mio_port
    import mio_pkg::*;
#(
    parameter int PW      = 8,
    parameter bit CTRL_RT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    reg_addr,
    input  logic [BUS_W-1:0] wr_data,
    output logic [BUS_W-1:0] rd_data,
    input  logic             ale,
    input  logic [PW-1:0]    ad_in,
    input  logic [PW-1:0]    mc_out,
    input  logic [PW-1:0]    pt_oe,
    input  logic [PW-1:0]    ecs_in,
    input  logic [2*PW-1:0]  cfg_osel,
    input  logic [PW-1:0]    cfg_oe_src,
    input  logic [PW-1:0]    pin_in,
    output logic [PW-1:0]    pin_out,
    output logic [PW-1:0]    pin_oe
);
    logic [PW-1:0] dout, dir, ctrl;
    logic [PW-1:0] addr_lat;

    always_latch begin
        if (!rst_n)   addr_lat = '0;
        else if (ale) addr_lat = ad_in;
    end

    mio_regs #(.PW(PW), .CTRL_RT(CTRL_RT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .pin_in(pin_in), .mc_out(mc_out),
        .dout(dout), .dir(dir), .ctrl(ctrl), .rd_data(rd_data)
    );

    mio_pin_mux #(.PW(PW), .CTRL_RT(CTRL_RT)) u_mux (
        .clk(clk), .rst_n(rst_n), .dout(dout), .dir(dir), .ctrl(ctrl),
        .addr_lat(addr_lat), .mc_out(mc_out), .pt_oe(pt_oe), .ecs_in(ecs_in),
        .cfg_osel(cfg_osel), .cfg_oe_src(cfg_oe_src),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // R5
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale ##1 !ale) |-> $stable(addr_lat));
endmodule

// File: tb/tb_mio_port.sv
module tb_mio_port;
    localparam int PW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic ale = 1'b0;
    logic [PW-1:0] ad_in = '0, mc_out = '0, pt_oe = '0, ecs_in = '0;
    logic [2*PW-1:0] cfg_osel = '0;
    logic [PW-1:0] cfg_oe_src = '0, pin_in = '0;
    logic [PW-1:0] pin_out, pin_oe;

    int n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    mio_port #(.PW(PW), .CTRL_RT(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .ale(ale), .ad_in(ad_in),
        .mc_out(mc_out), .pt_oe(pt_oe), .ecs_in(ecs_in), .cfg_osel(cfg_osel),
        .cfg_oe_src(cfg_oe_src), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    // table: {cfg_osel, ctrl}
    localparam int NV = 7;
    localparam logic [23:0] VEC [NV] = '{
        {16'h0000, 8'h00}, {16'h5555, 8'h00}, {16'hAAAA, 8'h00},
        {16'hFFFF, 8'h00}, {16'hE4E4, 8'h00}, {16'h1B1B, 8'h00},
        {16'hE4E4, 8'h0F}
    };

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [2:0] a, logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    function automatic logic [7:0] ref_out(logic [15:0] osel, logic [7:0] ctl,
        logic [7:0] d, logic [7:0] ad, logic [7:0] mc, logic [7:0] cs);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) begin
            if (ctl[i]) r[i] = ad[i];
            else case (osel[2*i +: 2])
                2'b00: r[i] = d[i];
                2'b01: r[i] = ad[i];
                2'b10: r[i] = mc[i];
                default: r[i] = cs[i];
            endcase
        end
        return r;
    endfunction

    initial begin
        #200000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 pin_out", pin_out, 8'h00);
        rd_chk("R1 dout", 3'd1, 8'h00);
        rd_chk("R1 dir", 3'd2, 8'h00);
        rd_chk("R1 ctrl", 3'd3, 8'h00);

        // R2 writes
        wr(3'd1, 8'hA5);
        wr(3'd2, 8'hC3);
        rd_chk("R2 dout", 3'd1, 8'hA5);
        rd_chk("R2 dir", 3'd2, 8'hC3);
        rd_chk("R2 ctrl untouched", 3'd3, 8'h00);

        // R5 address latch
        @(negedge clk); ad_in = 8'h3C; ale = 1'b1;
        @(negedge clk); ale = 1'b0; ad_in = 8'hFF;
        mc_out = 8'h96; ecs_in = 8'h0F;
        cfg_osel = 16'h5555;
        @(negedge clk); #1;
        check("R5 latch hold", pin_out, 8'h3C);
        ale = 1'b1; #1;
        check("R5 latch transparent", pin_out, 8'hFF);
        ad_in = 8'h3C; #1; ale = 1'b0;

        // R3 R4 R10 table walk
        for (int k = 0; k < NV; k++) begin
            cfg_osel = VEC[k][23:8];
            wr(3'd3, VEC[k][7:0]);
            #1;
            check($sformatf("R3/R4/R10 vec%0d", k), pin_out,
                  ref_out(VEC[k][23:8], VEC[k][7:0], 8'hA5, 8'h3C, 8'h96, 8'h0F));
        end
        wr(3'd3, 8'h00);

        // R6 enable source
        pt_oe = 8'h5A; cfg_oe_src = 8'h00; #1;
        check("R6 dir source", pin_oe, 8'hC3);
        cfg_oe_src = 8'hF0; #1;
        check("R6 mixed source R10", pin_oe, 8'h53);

        // R8 readback
        rd_chk("R8 mc live", 3'd4, 8'h96);
        mc_out = 8'h21;
        rd_chk("R8 mc follows", 3'd4, 8'h21);

        // R7 synchroniser
        @(negedge clk); pin_in = 8'h5A; reg_addr = 3'd0;
        @(negedge clk); #1;
        check("R7 one edge", rd_data, 8'h00);
        @(negedge clk); #1;
        check("R7 two edges", rd_data, 8'h5A);

        // R9 unmapped
        cfg_osel = 16'h0000; cfg_oe_src = 8'h00;
        wr(3'd5, 8'hFF);
        wr(3'd0, 8'h11);
        wr(3'd4, 8'h22);
        wr(3'd7, 8'h33);
        rd_chk("R9 read 5", 3'd5, 8'h00);
        rd_chk("R9 read 6", 3'd6, 8'h00);
        rd_chk("R9 read 7", 3'd7, 8'h00);
        rd_chk("R9 dout kept", 3'd1, 8'hA5);
        rd_chk("R9 dir kept", 3'd2, 8'hC3);
        rd_chk("R9 ctrl kept", 3'd3, 8'h00);
        check("R9 pin_out kept", pin_out, 8'hA5);

        // R1 reset again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        check("R1 re-reset oe", pin_oe, 8'h00);
        rd_chk("R1 re-reset dout", 3'd1, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule